// File: doc/BRIEF.md
# Platform System Control Registers

This block is a memory-mapped register file for platform control. It sits on a simple 32-bit request bus and decodes a 4 KiB byte window. The lower half of the window holds 512 general-purpose 32-bit words that firmware can read and write freely. Four of these words come out of reset with fixed identification and configuration values. Three of them also read back with two status bits forced high, and the stored contents are left as they were.

A write to one command location in the upper half of the window asks the platform either to reset or to shut down. The block drives a one-cycle request pulse. A separate reset controller, outside this block, acts on that pulse. Any access to the upper half stores nothing, reads as zero, and raises a one-cycle bad-access pulse. This also applies to the command location.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the word at byte offset 0x104 reads 0x00000002. The words at 0x100, 0x108 and 0x10C hold 0x05F20121, 0x05F30121 and 0x05F40121, and they read back with the status mask applied (see R4).
- R2: After reset, every other storage word (byte offsets 0x000 to 0x7FC) reads zero.
- R3: A write with req and we high stores wdata at word addr[11:2] on that clock edge. addr[1:0] are ignored. A read with req high and we low returns the word on rdata one clock later, and rdata holds its value until the next read.
- R4: A read of byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000 (bits 29 and 28 set). A read of any other offset returns the stored word unchanged.
- R5: A write to byte offset 0x800 or above stores nothing, and no storage word changes.
- R6: A read from byte offset 0x800 or above returns zero.
- R7: bad_acc pulses high for one cycle, in the cycle after any access at byte offset 0x800 or above. It stays low for accesses below 0x800.
- R8: A write of value 1 or 2 to byte offset 0xF00 makes rst_req pulse high for one cycle in the following cycle.
- R9: A write of value 3 to byte offset 0xF00 makes shdn_req pulse high for one cycle in the following cycle.
- R10: A write of any other value to 0xF00, and any read of 0xF00, raises neither rst_req nor shdn_req.
- R11: A command write to 0xF00 also counts as an out-of-range access. It raises bad_acc and stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | Write when high, read when low |
| addr | input | 12 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after a read request |
| rst_req | output | 1 | One-cycle system reset request |
| shdn_req | output | 1 | One-cycle shutdown request |
| bad_acc | output | 1 | One-cycle out-of-range access indication |

## Verification
The hardest case to show from the ports is that an out-of-range write has no effect on storage. If the upper address bit were dropped, such a write would land on the word whose offset is the same in the lower half. The bench therefore seeds those aliased words (0x010 and 0x700) with known values first. It then issues the out-of-range and command writes, and reads the seeded words back to confirm they are intact. Command pulses are sampled in the exact cycle after the write and again one cycle later, to show that each pulse lasts a single cycle.

// File: rtl/sysctl_pkg.sv
// Shared constants and helpers for the platform system control registers.
// Assumes a 32-bit word-addressed storage bank inside a byte-addressed window.
package sysctl_pkg;

    localparam logic [31:0] STATUS_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_kind_t;

    // Reset content of one storage word, selected by word index.
    function automatic logic [31:0] reset_word(input int unsigned idx);
        case (idx)
            'h40:    return 32'h05F2_0121;
            'h41:    return 32'h0000_0002;
            'h42:    return 32'h05F3_0121;
            'h43:    return 32'h05F4_0121;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Words that read back with the status mask ORed in.
    function automatic logic is_status_word(input int unsigned idx);
        return (idx == 'h40) || (idx == 'h42) || (idx == 'h43);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address and command decode. Purely combinational.
// Assumes addr is a byte address, and ignores its two low bits.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 512,
    parameter int CMD_OFFSET = 'hF00,
    localparam int IDX_W     = ADDR_W - 2,
    localparam int MEM_AW    = $clog2(DEPTH)
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [MEM_AW-1:0] mem_idx,
    output logic              wr_en,
    output logic              rd_en,
    output logic              in_range,
    output logic              status_rd,
    output logic              oor_hit,
    output cmd_kind_t         cmd
);
    logic [IDX_W-1:0] word_idx;
    logic             cmd_hit;

    // Split the address into word index and range flags.
    always_comb begin
        word_idx  = addr[ADDR_W-1:2];
        in_range  = (int'(word_idx) < DEPTH);
        mem_idx   = word_idx[MEM_AW-1:0];
        wr_en     = req && we && in_range;
        rd_en     = req && !we;
        status_rd = in_range && is_status_word(int'(word_idx));
        oor_hit   = req && !in_range;
        cmd_hit   = req && we && (int'(word_idx) == (CMD_OFFSET >> 2));
    end

    // Classify the value written to the command location.
    always_comb begin
        cmd = CMD_NONE;
        if (cmd_hit) begin
            if (wdata == DATA_W'(1) || wdata == DATA_W'(2)) cmd = CMD_RESET;
            else if (wdata == DATA_W'(3))                   cmd = CMD_SHUTDOWN;
        end
    end

endmodule

// File: rtl/sysctl_store.sv
// Storage bank of DEPTH words, each with a fixed reset value.
// Has one write port and one combinational read port, and assumes a
// synchronous active-low reset.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 512,
    localparam int MEM_AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Load reset values, or store one word on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(reset_word(i));
        end else if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    // Combinational read of the addressed word.
    always_comb rd_word = mem[idx];

endmodule

// File: rtl/sysctl_pulse.sv
// Registered single-cycle request pulses for commands and bad accesses.
// Assumes each qualifying access lasts one request cycle.
module sysctl_pulse
    import sysctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_t cmd,
    input  logic      oor_hit,
    output logic      rst_req,
    output logic      shdn_req,
    output logic      bad_acc
);
    // Turn this cycle's decode result into next-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            shdn_req <= 1'b0;
            bad_acc  <= 1'b0;
        end else begin
            rst_req  <= (cmd == CMD_RESET);
            shdn_req <= (cmd == CMD_SHUTDOWN);
            bad_acc  <= oor_hit;
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
// Platform system control register block, top level.
// It decodes a byte window, stores words, shapes read data with status bits
// and raises reset or shutdown request pulses. Reads return data one cycle
// after the request. Reset is synchronous and active low.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 512,
    parameter int CMD_OFFSET = 'hF00,
    localparam int MEM_AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req,
    output logic              shdn_req,
    output logic              bad_acc
);
    logic [MEM_AW-1:0] mem_idx;
    logic              wr_en, rd_en, in_range, status_rd, oor_hit;
    cmd_kind_t         cmd;
    logic [DATA_W-1:0] rd_word;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CMD_OFFSET(CMD_OFFSET)
    ) u_decode (
        .req(req), .we(we), .addr(addr), .wdata(wdata),
        .mem_idx(mem_idx), .wr_en(wr_en), .rd_en(rd_en), .in_range(in_range),
        .status_rd(status_rd), .oor_hit(oor_hit), .cmd(cmd)
    );

    sysctl_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(mem_idx),
        .wdata(wdata), .rd_word(rd_word)
    );

    sysctl_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .oor_hit(oor_hit),
        .rst_req(rst_req), .shdn_req(shdn_req), .bad_acc(bad_acc)
    );

    // Register shaped read data. Hold the last value when there is no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (!in_range)      rdata <= '0;
            else if (status_rd) rdata <= rd_word | DATA_W'(STATUS_MASK);
            else                rdata <= rd_word;
        end
    end

endmodule

// File: rtl/sysctl_regs_chk.sv
// Property checker for sysctl_regs, attached with bind.
module sysctl_regs_chk #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 512,
    parameter int CMD_OFFSET = 'hF00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rst_req,
    input logic              shdn_req,
    input logic              bad_acc
);
    logic oor_now, cmd_wr, stat_rd;

    // Reference flags built from the port values.
    always_comb begin
        oor_now = req && (int'(addr[ADDR_W-1:2]) >= DEPTH);
        cmd_wr  = req && we && (int'(addr[ADDR_W-1:2]) == (CMD_OFFSET >> 2));
        stat_rd = req && !we && ((addr[ADDR_W-1:2] == 'h40) ||
                  (addr[ADDR_W-1:2] == 'h42) || (addr[ADDR_W-1:2] == 'h43));
    end

    // R8
    reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(cmd_wr && (wdata == DATA_W'(1) || wdata == DATA_W'(2))));

    // R9
    shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |-> $past(cmd_wr && wdata == DATA_W'(3)));

    // R10
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && shdn_req));

    // R7
    bad_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oor_now |=> bad_acc);

    // R11
    cmd_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> bad_acc);

    // R6
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_now && !we) |=> (rdata == '0));

    // R4
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rdata[29:28] == 2'b11));

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CMD_OFFSET(CMD_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .shdn_req(shdn_req), .bad_acc(bad_acc)
);

// File: tb/sysctl_regs_test.sv
// Directed bench for sysctl_regs. Each scenario task checks its own results.
module sysctl_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req, shdn_req, bad_acc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] s_rdata;
    logic        s_rst, s_shdn, s_bad;

    sysctl_regs uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req),
        .shdn_req(shdn_req), .bad_acc(bad_acc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One access. Outputs are sampled just after the capturing edge.
    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk); #1;
        s_rdata = rdata; s_rst = rst_req; s_shdn = shdn_req; s_bad = bad_acc;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    // Sample the pulses one cycle after an access.
    task automatic idle_pulses(input string tag);
        @(posedge clk); #1;
        check({tag, " rst_req single cycle"}, 32'(rst_req), 32'd0);
        check({tag, " shdn_req single cycle"}, 32'(shdn_req), 32'd0);
        check({tag, " bad_acc single cycle"}, 32'(bad_acc), 32'd0);
    endtask

    task automatic t_reset;
        access(1'b0, 12'h100, '0); check("R1 0x100", s_rdata, 32'h35F2_0121);
        access(1'b0, 12'h104, '0); check("R1 0x104", s_rdata, 32'h0000_0002);
        access(1'b0, 12'h108, '0); check("R1 0x108", s_rdata, 32'h35F3_0121);
        access(1'b0, 12'h10C, '0); check("R1 0x10C", s_rdata, 32'h35F4_0121);
        access(1'b0, 12'h000, '0); check("R2 0x000", s_rdata, 32'h0);
        access(1'b0, 12'h7FC, '0); check("R2 0x7FC", s_rdata, 32'h0);
        access(1'b0, 12'h0FC, '0); check("R2 0x0FC", s_rdata, 32'h0);
        check("R7 no bad_acc in range", 32'(s_bad), 32'd0);
    endtask

    task automatic t_rw;
        access(1'b1, 12'h010, 32'hA5A5_5A5A);
        access(1'b0, 12'h013, '0); check("R3 low bits ignored", s_rdata, 32'hA5A5_5A5A);
        access(1'b1, 12'h7FC, 32'hCAFE_F00D);
        access(1'b0, 12'h7FC, '0); check("R3 top word", s_rdata, 32'hCAFE_F00D);
        repeat (3) @(posedge clk);
        #1 check("R3 rdata holds", rdata, 32'hCAFE_F00D);
    endtask

    task automatic t_status;
        access(1'b1, 12'h108, 32'h0);
        access(1'b0, 12'h108, '0); check("R4 status OR", s_rdata, 32'h3000_0000);
        access(1'b1, 12'h104, 32'h0);
        access(1'b0, 12'h104, '0); check("R4 non-status plain", s_rdata, 32'h0);
        access(1'b1, 12'h100, 32'h0000_1234);
        access(1'b0, 12'h100, '0); check("R4 0x100 shaped", s_rdata, 32'h3000_1234);
        access(1'b1, 12'h110, 32'h0);
        access(1'b0, 12'h110, '0); check("R4 0x110 plain", s_rdata, 32'h0);
    endtask

    task automatic t_oor;
        access(1'b1, 12'h810, 32'hDEAD_BEEF);
        check("R7 bad_acc on write", 32'(s_bad), 32'd1);
        check("R10 no rst_req on oor write", 32'(s_rst), 32'd0);
        idle_pulses("R7");
        access(1'b0, 12'h010, '0); check("R5 alias intact", s_rdata, 32'hA5A5_5A5A);
        access(1'b0, 12'h810, '0);
        check("R6 oor read zero", s_rdata, 32'h0);
        check("R7 bad_acc on read", 32'(s_bad), 32'd1);
    endtask

    task automatic t_cmd;
        access(1'b1, 12'h700, 32'h1122_3344);
        access(1'b1, 12'hF00, 32'd1);
        check("R8 value 1", 32'(s_rst), 32'd1);
        check("R9 no shdn on 1", 32'(s_shdn), 32'd0);
        check("R11 bad_acc on cmd", 32'(s_bad), 32'd1);
        idle_pulses("R8");
        access(1'b1, 12'hF00, 32'd2);
        check("R8 value 2", 32'(s_rst), 32'd1);
        access(1'b1, 12'hF02, 32'd3);
        check("R9 value 3", 32'(s_shdn), 32'd1);
        check("R9 no rst on 3", 32'(s_rst), 32'd0);
        idle_pulses("R9");
        access(1'b1, 12'hF00, 32'd4);
        check("R10 value 4 rst", 32'(s_rst), 32'd0);
        check("R10 value 4 shdn", 32'(s_shdn), 32'd0);
        check("R11 bad_acc value 4", 32'(s_bad), 32'd1);
        access(1'b1, 12'hF00, 32'h0000_0101);
        check("R10 value 0x101 rst", 32'(s_rst), 32'd0);
        access(1'b0, 12'hF00, '0);
        check("R10 read no rst", 32'(s_rst), 32'd0);
        check("R10 read no shdn", 32'(s_shdn), 32'd0);
        check("R6 cmd read zero", s_rdata, 32'h0);
        access(1'b0, 12'h700, '0); check("R11 nothing stored", s_rdata, 32'h1122_3344);
    endtask

    task automatic t_post_reset;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        access(1'b0, 12'h010, '0); check("R2 cleared by reset", s_rdata, 32'h0);
        access(1'b0, 12'h104, '0); check("R1 reloaded", s_rdata, 32'h2);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2 rdata at reset", rdata, 32'h0);
        check("R8 rst_req at reset", 32'(rst_req), 32'd0);
        check("R7 bad_acc at reset", 32'(bad_acc), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_rw();
        t_status();
        t_oor();
        t_cmd();
        t_post_reset();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule